// File: doc/BRIEF.md
# Projector Power-State and Park Sequencer

This block runs the bring-up and shut-down sequence of a micromirror display controller. It watches three active-low inputs: a power reset from the supply controller, an emergency park line that warns of imminent power loss, and a normal park request from the host. From these it drives the mirror driver enable, the LED colour select, a host interrupt with its own output enable, a flag that allows the I2C slave to be used, a strobe with an output enable for the test-mode strap pins, and a one-cycle done pulse that tells the power controller the mirrors are parked.

One timebase measures every interval. It divides the system clock down to a 1 µs tick, and the divider is worked out from the `CLK_HZ` parameter. The init time, the I2C lockout, the minimum width of a park request and the two park timeouts are parameters counted in microseconds. The strap sampling delay is a parameter in nanoseconds and is counted in clock cycles. Mirror motion is handled by another block. That block raises `mirror_parked` when the mirrors are at rest; if it never does, the park ends when its timeout expires.

All inputs are synchronous to `clk`. `rst_n` is the local asynchronous reset of the logic. `pwr_rst_n` is the system-level reset that the block sequences.

Top module: `proj_park_seq`

## Requirements
- R1: While `pwr_rst_n` is low, these outputs are all 0: `drv_en`, `led_sel`, `irq_out`, `irq_oe`, `i2c_ok`, `strap_sample`, `strap_drive` and `park_done`. The sequencer returns to its idle state on the next clock.
- R2: Initialization starts only on a low-to-high transition of `pwr_rst_n`. If `pwr_rst_n` is already high when `rst_n` is released, the block stays idle with `irq_oe` = 0 and `drv_en` = 0.
- R3: After the rising edge, `irq_oe` = 1 and `irq_out` = 1 (busy) for INIT_US µs. Then `irq_out` falls to 0 (done) and `drv_en` rises in the same cycle.
- R4: `strap_sample` is high for exactly one cycle, about STRAP_NS ns after the rising edge. From the cycle after that strobe, `strap_drive` stays high until reset.
- R5: `i2c_ok` rises after `pwr_rst_n` and `fast_park_n` have both been high for I2C_LOCK_US µs. If either input goes low, `i2c_ok` drops at once and the lockout count starts again.
- R6: A level change on `park_req_n` counts only once it has held for PULSE_MIN_US µs. Shorter pulses, low or high, are ignored.
- R7: Once a low request has been accepted, `drv_en` stays 1 until `mirror_parked` is 1 or NORM_PARK_US µs have passed. `drv_en` then goes to 0 and `park_done` pulses for one cycle.
- R8: After a normal park, an accepted high level on `park_req_n` sets `drv_en` back to 1 without a new initialization. `irq_out` stays 0.
- R9: When `fast_park_n` goes low, `drv_en` falls and `park_done` pulses within FAST_PARK_US µs. The block then stays parked until the next `pwr_rst_n` cycle.
- R10: A low on `fast_park_n` during a normal park replaces that park with a fast park on the next clock.
- R11: `led_sel` equals `led_sel_req` only while the block is running and not parking. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset of the block logic |
| pwr_rst_n | input | 1 | System-level active-low reset being sequenced |
| fast_park_n | input | 1 | Active-low emergency park (power loss imminent) |
| park_req_n | input | 1 | Active-low normal park request from the host |
| mirror_parked | input | 1 | Mirror engine reports the mirrors are at rest |
| led_sel_req | input | 2 | LED colour select from the sequence engine |
| drv_en | output | 1 | Mirror driver enable; low holds the driver in reset |
| led_sel | output | 2 | Gated LED colour select |
| irq_out | output | 1 | Host interrupt level: 1 = initializing, 0 = ready |
| irq_oe | output | 1 | Output enable for the host interrupt pad |
| i2c_ok | output | 1 | I2C access permitted |
| strap_sample | output | 1 | One-cycle strobe that captures the test straps |
| strap_drive | output | 1 | Strap pins switched to output mode |
| park_done | output | 1 | One-cycle pulse when a park has completed |

## Verification
The hardest state to reach from the ports is a fast park that cuts into a normal park still in progress. Getting there needs a park request that has already passed the pulse filter, while the mirror engine deliberately never reports the mirrors at rest, so the normal park is still open when `fast_park_n` falls. The stimulus also puts random short glitches on the request line while `mirror_parked` is held high. If the filter ever let a glitch through, the park would finish immediately and show up as a `park_done` pulse.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_INIT   = 3'd1,
    ST_RUN    = 3'd2,
    ST_PNORM  = 3'd3,
    ST_PFAST  = 3'd4,
    ST_HALT_N = 3'd5,
    ST_HALT_F = 3'd6
  } pps_state_e;

  function automatic logic is_halt(input pps_state_e s);
    return (s == ST_HALT_N) || (s == ST_HALT_F);
  endfunction

endpackage

// File: rtl/pps_tick.sv
module pps_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_pass
      logic on_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) on_q <= 1'b0;
        else        on_q <= 1'b1;
      end
      assign tick_o = on_q;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      logic [W-1:0] cnt_q, cnt_d;
      logic         wrap;
      assign wrap = (cnt_q == W'(DIV - 1));
      always_comb cnt_d = wrap ? '0 : cnt_q + 1'b1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
      assign tick_o = wrap;
    end
  endgenerate

endmodule

// File: rtl/pps_req_filter.sv
module pps_req_filter #(
  parameter int MIN_TICKS = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  input  logic raw_act_i,
  output logic req_o
);

  localparam int CW = $clog2(MIN_TICKS + 1);

  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (clr_i) begin
      filt_d = 1'b0;
      cnt_d  = '0;
    end else if (raw_act_i == filt_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == CW'(MIN_TICKS - 1)) begin
        filt_d = raw_act_i;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign req_o = filt_q;

  // R6: an accepted level always equals the raw level that was held
  a_r6_accept_matches_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(req_o) && !$past(clr_i)) |-> (req_o == $past(raw_act_i)));

endmodule

// File: rtl/proj_park_seq.sv
module proj_park_seq
  import pps_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int INIT_US      = 1000,
  parameter int I2C_LOCK_US  = 500_000,
  parameter int PULSE_MIN_US = 200_000,
  parameter int NORM_PARK_US = 20_000,
  parameter int FAST_PARK_US = 40,
  parameter int STRAP_NS     = 1500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_rst_n,
  input  logic       fast_park_n,
  input  logic       park_req_n,
  input  logic       mirror_parked,
  input  logic [1:0] led_sel_req,
  output logic       drv_en,
  output logic [1:0] led_sel,
  output logic       irq_out,
  output logic       irq_oe,
  output logic       i2c_ok,
  output logic       strap_sample,
  output logic       strap_drive,
  output logic       park_done
);

  localparam int TICK_DIV  = CLK_HZ / 1_000_000;
  localparam int STRAP_RAW = (CLK_HZ / 1000) * STRAP_NS / 1_000_000;
  localparam int STRAP_CYC = (STRAP_RAW < 1) ? 1 : STRAP_RAW;
  localparam int MAX_A     = (INIT_US > NORM_PARK_US) ? INIT_US : NORM_PARK_US;
  localparam int MAX_T     = (MAX_A > FAST_PARK_US) ? MAX_A : FAST_PARK_US;
  localparam int TW        = $clog2(MAX_T + 2);
  localparam int LW        = $clog2(I2C_LOCK_US + 1);
  localparam int SW        = $clog2(STRAP_CYC + 2);

  logic tick;
  logic req_act;

  pps_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  pps_req_filter #(.MIN_TICKS(PULSE_MIN_US)) u_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (~pwr_rst_n),
    .tick_i    (tick),
    .raw_act_i (~park_req_n),
    .req_o     (req_act)
  );

  pps_state_e    st_q, st_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [LW-1:0] lock_q, lock_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic          pwr_q, done_q, done_d;
  logic          pwr_rise, park_end_n, park_end_f;

  assign pwr_rise   = pwr_rst_n & ~pwr_q;
  assign park_end_n = mirror_parked || (tcnt_q >= TW'(NORM_PARK_US));
  assign park_end_f = mirror_parked || (tcnt_q >= TW'(FAST_PARK_US));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:    if (pwr_rise) st_d = ST_INIT;
      ST_INIT:   if (!fast_park_n) st_d = ST_HALT_F;
                 else if (tcnt_q >= TW'(INIT_US)) st_d = ST_RUN;
      ST_RUN:    if (!fast_park_n) st_d = ST_PFAST;
                 else if (req_act) st_d = ST_PNORM;
      ST_PNORM:  if (!fast_park_n) st_d = ST_PFAST;
                 else if (park_end_n) st_d = ST_HALT_N;
      ST_PFAST:  if (park_end_f) st_d = ST_HALT_F;
      ST_HALT_N: if (!fast_park_n) st_d = ST_HALT_F;
                 else if (!req_act) st_d = ST_RUN;
      ST_HALT_F: st_d = ST_HALT_F;
      default:   st_d = ST_OFF;
    endcase
    if (!pwr_rst_n) st_d = ST_OFF;
  end

  always_comb begin
    if (st_d != st_q)                 tcnt_d = '0;
    else if (tick && (tcnt_q != '1))  tcnt_d = tcnt_q + 1'b1;
    else                              tcnt_d = tcnt_q;
  end

  always_comb done_d = pwr_rst_n && is_halt(st_d) && !is_halt(st_q);

  always_comb begin
    if (!(pwr_rst_n && fast_park_n))              lock_d = '0;
    else if (tick && (lock_q != LW'(I2C_LOCK_US))) lock_d = lock_q + 1'b1;
    else                                           lock_d = lock_q;
  end

  always_comb begin
    if (!pwr_rst_n)                                       scnt_d = '0;
    else if (pwr_rise)                                    scnt_d = SW'(1);
    else if ((scnt_q != '0) && (scnt_q <= SW'(STRAP_CYC))) scnt_d = scnt_q + 1'b1;
    else                                                  scnt_d = scnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      tcnt_q <= '0;
      lock_q <= '0;
      scnt_q <= '0;
      pwr_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      lock_q <= lock_d;
      scnt_q <= scnt_d;
      pwr_q  <= pwr_rst_n;
      done_q <= done_d;
    end
  end

  assign drv_en       = pwr_rst_n && ((st_q == ST_RUN) || (st_q == ST_PNORM) || (st_q == ST_PFAST));
  assign led_sel      = (pwr_rst_n && (st_q == ST_RUN)) ? led_sel_req : 2'b00;
  assign irq_oe       = pwr_rst_n && (st_q != ST_OFF);
  assign irq_out      = pwr_rst_n && (st_q == ST_INIT);
  assign i2c_ok       = pwr_rst_n && fast_park_n && (lock_q == LW'(I2C_LOCK_US));
  assign strap_sample = pwr_rst_n && (scnt_q == SW'(STRAP_CYC));
  assign strap_drive  = pwr_rst_n && (scnt_q > SW'(STRAP_CYC));
  assign park_done    = pwr_rst_n && done_q;

  // R1: reset low sends the sequencer to idle on the next clock
  a_r1_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_rst_n |=> (st_q == ST_OFF));

  // R2: initialization is entered only after the reset pin was seen low
  a_r2_init_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_INIT) && ($past(st_q) == ST_OFF)) |-> !$past(pwr_q));

  // R4: strap strobe lasts a single cycle
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strap_sample |=> !strap_sample);

  // R4: strap pins switch to output only right after the strobe
  a_r4_drive_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_drive) |-> $past(strap_sample));

  // R5: access permission never rises unless both inputs were high
  a_r5_lock_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i2c_ok) |-> $past(pwr_rst_n && fast_park_n));

  // R7: done is only reported with the driver off
  a_r7_done_drv_low: assert property (@(posedge clk) disable iff (!rst_n)
    park_done |-> !drv_en);

  // R9: a fast park never runs past its bound
  a_r9_fast_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PFAST) |-> (tcnt_q <= TW'(FAST_PARK_US)));

  // R10: emergency park overrides a normal park in progress
  a_r10_fast_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_PNORM) && !fast_park_n && pwr_rst_n) |=> (st_q == ST_PFAST));

endmodule

// File: tb/sim_proj_park_seq.sv
module sim_proj_park_seq;

  localparam int CLK_HZ = 50_000_000;
  localparam int CPU    = 50;
  localparam int P_INIT = 20;
  localparam int P_LOCK = 60;
  localparam int P_PUL  = 30;
  localparam int P_NORM = 25;
  localparam int P_FAST = 4;
  localparam int P_STRP = 1500;
  localparam int STRAP_CYC = 75;
  localparam int SLACK  = 60;

  logic clk = 1'b0;
  logic rst_n, pwr_rst_n, fast_park_n, park_req_n, mirror_parked;
  logic [1:0] led_sel_req, led_sel;
  logic drv_en, irq_out, irq_oe, i2c_ok, strap_sample, strap_drive, park_done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  proj_park_seq #(
    .CLK_HZ(CLK_HZ), .INIT_US(P_INIT), .I2C_LOCK_US(P_LOCK), .PULSE_MIN_US(P_PUL),
    .NORM_PARK_US(P_NORM), .FAST_PARK_US(P_FAST), .STRAP_NS(P_STRP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_rst_n(pwr_rst_n), .fast_park_n(fast_park_n),
    .park_req_n(park_req_n), .mirror_parked(mirror_parked), .led_sel_req(led_sel_req),
    .drv_en(drv_en), .led_sel(led_sel), .irq_out(irq_out), .irq_oe(irq_oe),
    .i2c_ok(i2c_ok), .strap_sample(strap_sample), .strap_drive(strap_drive),
    .park_done(park_done)
  );

  function automatic int us2cyc(input int us);
    return us * CPU;
  endfunction

  function automatic logic [1:0] exp_led(input bit running, input logic [1:0] req);
    return running ? req : 2'b00;
  endfunction

  function automatic int quiet_bits();
    return int'(drv_en) + int'(led_sel != 2'b00) + int'(irq_out) + int'(irq_oe) +
           int'(i2c_ok) + int'(strap_sample) + int'(strap_drive) + int'(park_done);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int v, input int lo, input int hi);
    checks++;
    if (v < lo || v > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, v, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns the number of cycles until park_done is seen, or -1 on timeout
  task automatic time_done(input int limit, output int t);
    t = -1;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (park_done) begin t = n; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t_stb, stb_w, t_irq, t_drv, t_i2c, led_bad, sdrv_bad, t, seen, low;
    int len;
    logic [1:0] v;
    logic prev_drv;
    void'($urandom(32'h1f3c_5a77));
    rst_n = 1'b0; pwr_rst_n = 1'b1; fast_park_n = 1'b1; park_req_n = 1'b1;
    mirror_parked = 1'b0; led_sel_req = 2'b11;
    cyc(4);
    chk(quiet_bits() == 3 ? 1'b0 : (drv_en == 0 && irq_oe == 0), "R1 local reset quiet", quiet_bits(), 0);
    rst_n = 1'b1;
    // R2: pin already high at release, no edge, must stay idle
    cyc(us2cyc(P_INIT + 10));
    chk(irq_oe == 0, "R2 no init without edge irq_oe", irq_oe, 0);
    chk(drv_en == 0, "R2 no init without edge drv_en", drv_en, 0);

    // R1: reset pin low forces every output inactive
    pwr_rst_n = 1'b0; led_sel_req = 2'($urandom % 3 + 1);
    cyc(us2cyc(3));
    chk(quiet_bits() == 0, "R1 outputs inactive in reset", quiet_bits(), 0);

    // Release and time the whole start-up in one pass
    t_stb = -1; stb_w = 0; t_irq = -1; t_drv = -1; t_i2c = -1; led_bad = 0; sdrv_bad = 0;
    pwr_rst_n = 1'b1;
    for (int n = 1; n <= us2cyc(P_LOCK) + 200; n++) begin
      @(negedge clk);
      if (n == 1) chk(irq_oe && irq_out, "R3 busy right after release", int'(irq_out), 1);
      if (strap_sample) begin stb_w++; if (t_stb < 0) t_stb = n; end
      if (t_stb > 0 && n > t_stb && !strap_drive) sdrv_bad++;
      if (t_irq < 0 && !irq_out) t_irq = n;
      if (t_drv < 0 && drv_en) t_drv = n;
      if (t_i2c < 0 && i2c_ok) t_i2c = n;
      if (irq_out && led_sel != 2'b00) led_bad++;
    end
    chk_rng("R4 strap strobe delay", t_stb, STRAP_CYC - 2, STRAP_CYC + 2);
    chk(stb_w == 1, "R4 strap strobe width", stb_w, 1);
    chk(sdrv_bad == 0, "R4 strap drive held", sdrv_bad, 0);
    chk_rng("R3 init duration", t_irq, us2cyc(P_INIT) - SLACK, us2cyc(P_INIT) + SLACK);
    chk(t_drv == t_irq, "R3 driver on with done", t_drv, t_irq);
    chk_rng("R5 lockout duration", t_i2c, us2cyc(P_LOCK) - SLACK, us2cyc(P_LOCK) + SLACK);
    chk(led_bad == 0, "R11 led off during init", led_bad, 0);

    // R11: random LED selects pass in running state
    for (int i = 0; i < 4; i++) begin
      v = 2'($urandom % 4);
      led_sel_req = v;
      @(negedge clk);
      chk(led_sel == exp_led(1'b1, v), "R11 led passthrough", led_sel, exp_led(1'b1, v));
    end

    // R6: short random glitches on the request are ignored
    mirror_parked = 1'b1;
    for (int i = 0; i < 3; i++) begin
      len = 1 + int'($urandom % (P_PUL / 2));
      park_req_n = 1'b0;
      cyc(us2cyc(len));
      park_req_n = 1'b1;
      seen = 0; low = 0;
      for (int n = 0; n < us2cyc(P_PUL + 5); n++) begin
        @(negedge clk);
        if (park_done) seen++;
        if (!drv_en) low++;
      end
      chk(seen == 0, "R6 glitch gave no park", seen, 0);
      chk(low == 0, "R6 glitch kept driver on", low, 0);
    end

    // R7: normal park that ends by timeout
    mirror_parked = 1'b0; led_sel_req = 2'b11;
    park_req_n = 1'b0;
    t = -1; prev_drv = 1'b0;
    for (int n = 1; n <= us2cyc(P_PUL + P_NORM + 10); n++) begin
      @(negedge clk);
      if (park_done) begin t = n; break; end
      prev_drv = drv_en;
    end
    chk_rng("R7 timeout park duration", t, us2cyc(P_PUL + P_NORM) - 2 * SLACK,
            us2cyc(P_PUL + P_NORM) + 2 * SLACK);
    chk(prev_drv == 1'b1, "R7 driver on until done", prev_drv, 1);
    chk(drv_en == 1'b0, "R7 driver off at done", drv_en, 0);
    @(negedge clk);
    chk(park_done == 1'b0, "R7 done is one cycle", park_done, 0);
    chk(led_sel == exp_led(1'b0, led_sel_req), "R11 led off when parked", led_sel, 0);

    // R8: short release ignored, long release resumes without init
    park_req_n = 1'b1; cyc(us2cyc(5)); park_req_n = 1'b0;
    cyc(us2cyc(P_PUL + 5));
    chk(drv_en == 1'b0, "R8 short release ignored", drv_en, 0);
    park_req_n = 1'b1;
    t = -1;
    for (int n = 1; n <= us2cyc(P_PUL + 5); n++) begin
      @(negedge clk);
      if (drv_en) begin t = n; break; end
    end
    chk_rng("R8 resume delay", t, us2cyc(P_PUL) - SLACK, us2cyc(P_PUL) + SLACK);
    chk(irq_out == 1'b0 && irq_oe == 1'b1, "R8 no re-init", irq_out, 0);

    // R7: park that ends early on mirror report
    mirror_parked = 1'b1;
    park_req_n = 1'b0;
    time_done(us2cyc(P_PUL + P_NORM + 10), t);
    chk_rng("R7 early park end", t, us2cyc(P_PUL) - SLACK, us2cyc(P_PUL) + SLACK);
    park_req_n = 1'b1;
    cyc(us2cyc(P_PUL + 3));
    chk(drv_en == 1'b1, "R8 running again", drv_en, 1);
    mirror_parked = 1'b0;

    // R10: fast park cuts into a normal park
    park_req_n = 1'b0;
    cyc(us2cyc(P_PUL + 5));
    chk(drv_en == 1'b1, "R10 normal park still open", drv_en, 1);
    fast_park_n = 1'b0;
    @(negedge clk);
    chk(i2c_ok == 1'b0, "R5 fast park drops access", i2c_ok, 0);
    time_done(us2cyc(P_NORM), t);
    chk_rng("R10 fast park bound", t, us2cyc(P_FAST - 1) - 5, us2cyc(P_FAST + 1) + 5);

    // R9: stays parked after the emergency
    fast_park_n = 1'b1; park_req_n = 1'b1;
    seen = 0;
    for (int n = 0; n < us2cyc(P_PUL + 10); n++) begin
      @(negedge clk);
      if (drv_en) seen++;
    end
    chk(seen == 0, "R9 stays parked", seen, 0);

    // R1 again, then fast park from running
    pwr_rst_n = 1'b0; led_sel_req = 2'b10;
    @(negedge clk);
    chk(quiet_bits() == 0, "R1 outputs inactive on re-reset", quiet_bits(), 0);
    cyc(us2cyc(3));
    pwr_rst_n = 1'b1;
    cyc(us2cyc(P_INIT + 5));
    chk(drv_en == 1'b1, "R3 running after re-init", drv_en, 1);
    fast_park_n = 1'b0;
    time_done(us2cyc(P_NORM), t);
    chk_rng("R9 fast park from running", t, us2cyc(P_FAST - 1) - 5, us2cyc(P_FAST + 1) + 5);
    chk(drv_en == 1'b0, "R9 driver off", drv_en, 0);

    // R5: lockout restarts once the park line returns high
    fast_park_n = 1'b1;
    t = -1;
    for (int n = 1; n <= us2cyc(P_LOCK) + 200; n++) begin
      @(negedge clk);
      if (i2c_ok) begin t = n; break; end
    end
    chk_rng("R5 lockout restart", t, us2cyc(P_LOCK) - SLACK, us2cyc(P_LOCK) + SLACK);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule